// File: doc/BRIEF.md
# Variable-Length PWM with Auto-Reload

A single pulse-width modulation channel clocked by a free-running 16-bit counter. In the short modes the PWM period is 2^(8+L) clocks, where the 3-bit length field L selects a period of 8 to 15 bits. A wide mode uses the whole 16-bit counter as the period and ignores the length field. A byte-wide register port gives software access to four addresses: a configuration byte, the low and high bytes of a 16-bit compare value, and a mode byte. A shadow 16-bit reload register sits at the same two byte addresses as the compare value. A select bit in the configuration byte picks which of the two the port reaches.

In the 9- to 15-bit modes, and in the wide mode when its reload enable is set, the compare value is copied from the shadow register on the same edge on which the period wraps. Software can therefore prepare the next duty value at any point in the period without disturbing the current one. A sticky period-end flag records each wrap in the 9- to 15-bit modes. An interrupt request is raised while both that flag and its enable bit are set.

Top module: `var_pwm`

## Requirements
- R1: After reset every register reads 0. Configuration byte (address 0) layout: bit0 bank select, bit1 period flag, bit2 interrupt enable, bit3 wide-mode reload enable, bits6:4 length L, bit7 always reads 0. The mode byte (address 3) holds the wide-mode enable in bit0, and its other bits read 0.
- R2: Addresses 1 (bits 7:0) and 2 (bits 15:8) read and write the compare value when bank select is 0 and the shadow reload value when it is 1.
- R3: The counter advances by one on every clock. The active width is n = 8+L, or 16 in wide mode. pwm_o is 1 exactly while the counter's low n bits are below the compare value's low n bits, so a compare value of 0 gives a constant 0 and a 256-clock 8-bit period with compare 0x40 is high for 64 clocks.
- R4: With L in 1..7 and wide mode off, the compare value takes the shadow value on the edge where the low n counter bits wrap from all ones to 0. A shadow write in mid-period leaves the current compare value unchanged, and the reload wins over a compare write in the same cycle.
- R5: With L = 0 and wide mode off, the shadow value is never copied and the period flag is never set by hardware.
- R6: With L in 1..7 and wide mode off, the period flag is set at each wrap and stays set. A configuration write with bit1 = 0 clears it and one with bit1 = 1 sets it.
- R7: When a wrap and a configuration write that clears the flag fall in the same cycle, the flag ends up set.
- R8: irq_o is 1 exactly while both the period flag and the interrupt enable are 1.
- R9: In wide mode the length field is ignored, the hardware never sets the period flag, and with the reload enable at 1 the compare value takes the shadow value when the 16-bit counter wraps.
- R10: In wide mode with the reload enable at 0 the shadow register has no effect, and the compare value changes only through software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the register port |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write takes effect on the clock edge that samples it. The read data reflects the registers combinationally, so a read in the following low clock phase already shows the new value. pwm_o and irq_o follow the counter and the registers with no further delay. The reload and the flag set land on the wrap edge itself, which is the edge sampled while the counter's low n bits are all ones. The bench drives inputs just after the falling edge and compares all three outputs against its own reference model one nanosecond later, in every cycle. To create the same-cycle cases it waits until its own counter shows the cycle before a wrap and then issues the write.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = 2 * DATA_W;
  localparam int LEN_W    = 3;
  localparam int BASE_LEN = 8;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd2;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd3;

  localparam int B_SEL  = 0;
  localparam int B_FLAG = 1;
  localparam int B_IE   = 2;
  localparam int B_AR16 = 3;
  localparam int B_LEN  = 4;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             ar16;
    logic             ie;
    logic             flag;
    logic             sel;
  } cfg_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int LW = LEN_W,
  parameter int BL = BASE_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] len_i,
  input  logic          wide_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] mask_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   one_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(1);
  end

  always_comb begin
    one_sh = (CW+1)'(1) << (BL + 32'(len_i));
    mask_o = wide_i ? '1 : (one_sh[CW-1:0] - CW'(1));
  end

  assign wrap_o = (cnt_q & mask_o) == mask_o;
  assign cnt_o  = cnt_q;

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp
  import pwm_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] mask_i,
  input  logic [CW-1:0] cmp_i,
  output logic          pwm_o
);
  logic [CW-1:0] cnt_m, cmp_m;
  assign cnt_m = cnt_i & mask_i;
  assign cmp_m = cmp_i & mask_i;
  assign pwm_o = cnt_m < cmp_m;

  assert_zero_duty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_m == '0) |-> !pwm_o);
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          wrap_i,
  output cfg_t          cfg_o,
  output logic          wide_o,
  output logic [CW-1:0] cmp_o,
  output logic          irq_o
);
  cfg_t          cfg_q;
  logic          wide_q;
  logic [CW-1:0] cmp_q, rld_q;
  logic          long_mode, reload_ev, hw_set;
  logic          wr_cfg, wr_lo, wr_hi;

  assign long_mode = !wide_q && (cfg_q.len != '0);
  assign hw_set    = wrap_i && long_mode;
  assign reload_ev = wrap_i && (wide_q ? cfg_q.ar16 : long_mode);
  assign wr_cfg    = wr_i && (addr_i == A_CFG);
  assign wr_lo     = wr_i && (addr_i == A_LO);
  assign wr_hi     = wr_i && (addr_i == A_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      wide_q <= 1'b0;
      cmp_q  <= '0;
      rld_q  <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q.sel  <= wdata_i[B_SEL];
        cfg_q.flag <= wdata_i[B_FLAG];
        cfg_q.ie   <= wdata_i[B_IE];
        cfg_q.ar16 <= wdata_i[B_AR16];
        cfg_q.len  <= wdata_i[B_LEN +: LEN_W];
      end
      if (hw_set) cfg_q.flag <= 1'b1;  // hardware set beats software clear
      if (wr_i && addr_i == A_MODE) wide_q <= wdata_i[0];
      if (cfg_q.sel) begin
        if (wr_lo) rld_q[DW-1:0]  <= wdata_i;
        if (wr_hi) rld_q[CW-1:DW] <= wdata_i;
      end
      if (reload_ev) cmp_q <= rld_q;
      else if (!cfg_q.sel) begin
        if (wr_lo) cmp_q[DW-1:0]  <= wdata_i;
        if (wr_hi) cmp_q[CW-1:DW] <= wdata_i;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CFG:   rdata_o = {1'b0, cfg_q};
      A_LO:    rdata_o = cfg_q.sel ? rld_q[DW-1:0]  : cmp_q[DW-1:0];
      A_HI:    rdata_o = cfg_q.sel ? rld_q[CW-1:DW] : cmp_q[CW-1:DW];
      default: rdata_o = {{(DW-1){1'b0}}, wide_q};
    endcase
  end

  assign cfg_o  = cfg_q;
  assign wide_o = wide_q;
  assign cmp_o  = cmp_q;
  assign irq_o  = cfg_q.flag & cfg_q.ie;

  assert_cfg_msb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CFG) |-> !rdata_o[DW-1]);
  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && long_mode) |=> cmp_q == $past(rld_q));
  assert_hw_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && long_mode) |=> cfg_q.flag);
  assert_hw_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && long_mode && wr_cfg && !wdata_i[B_FLAG]) |=> cfg_q.flag);
  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cfg_q.ie && cfg_q.flag));
  assert_wide_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && wide_q && cfg_q.ar16) |=> cmp_q == $past(rld_q));
  assert_plain_cmp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_q && !cfg_q.ar16 && !((wr_lo || wr_hi) && !cfg_q.sel)) |=> $stable(cmp_q));
endmodule

// File: rtl/var_pwm.sv
module var_pwm
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o,
  output logic              irq_o
);
  cfg_t             cfg;
  logic             wide, wrap;
  logic [CNT_W-1:0] cnt, mask, cmp;

  pwm_timebase #(.CW(CNT_W), .LW(LEN_W), .BL(BASE_LEN)) i_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .len_i  (cfg.len),
    .wide_i (wide),
    .cnt_o  (cnt),
    .mask_o (mask),
    .wrap_o (wrap)
  );

  pwm_regs #(.DW(DATA_W), .CW(CNT_W), .AW(ADDR_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .wrap_i  (wrap),
    .cfg_o   (cfg),
    .wide_o  (wide),
    .cmp_o   (cmp),
    .irq_o   (irq_o)
  );

  pwm_cmp #(.CW(CNT_W)) i_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt),
    .mask_i (mask),
    .cmp_i  (cmp),
    .pwm_o  (pwm_o)
  );
endmodule

// File: tb/test_var_pwm.sv
module test_var_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwm, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  var_pwm i_var_pwm (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt, m_cmp, m_rld;
  logic        m_sel, m_flag, m_ie, m_ar16, m_wide;
  logic [2:0]  m_len;

  function automatic logic [15:0] m_mask();
    if (m_wide) return 16'hFFFF;
    return 16'((17'd1 << (8 + 32'(m_len))) - 17'd1);
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return {1'b0, m_len, m_ar16, m_ie, m_flag, m_sel};
      2'd1:    return m_sel ? m_rld[7:0]  : m_cmp[7:0];
      2'd2:    return m_sel ? m_rld[15:8] : m_cmp[15:8];
      default: return {7'd0, m_wide};
    endcase
  endfunction

  function automatic logic [7:0] cfgb(input logic sel, flag, ie, ar16, input logic [2:0] len);
    return {1'b0, len, ar16, ie, flag, sel};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cmp <= '0; m_rld <= '0;
      m_sel <= 0; m_flag <= 0; m_ie <= 0; m_ar16 <= 0; m_wide <= 0; m_len <= '0;
    end else begin : step
      logic [15:0] mk;
      logic wrp, lng, rel, nflag;
      mk  = m_mask();
      wrp = (m_cnt & mk) == mk;
      lng = !m_wide && m_len != 0;
      rel = wrp && (m_wide ? m_ar16 : lng);
      nflag = m_flag;
      m_cnt <= m_cnt + 16'd1;
      if (wr && addr == 2'd0) begin
        m_sel <= wdata[0]; nflag = wdata[1]; m_ie <= wdata[2];
        m_ar16 <= wdata[3]; m_len <= wdata[6:4];
      end
      if (wrp && lng) nflag = 1'b1;
      m_flag <= nflag;
      if (wr && addr == 2'd3) m_wide <= wdata[0];
      if (wr && m_sel && addr == 2'd1) m_rld[7:0]  <= wdata;
      if (wr && m_sel && addr == 2'd2) m_rld[15:8] <= wdata;
      if (rel) m_cmp <= m_rld;
      else if (wr && !m_sel && addr == 2'd1) m_cmp[7:0]  <= wdata;
      else if (wr && !m_sel && addr == 2'd2) m_cmp[15:8] <= wdata;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock; outputs compared 1 ns after the falling edge
  task automatic tick();
    logic [15:0] mk;
    @(negedge clk); #1;
    mk = m_mask();
    chk("R3 pwm_o", 16'(pwm), 16'((m_cnt & mk) < (m_cmp & mk)));
    chk("R8 irq_o", 16'(irq), 16'(m_flag & m_ie));
    chk("R2 rdata_o", 16'(rdata), 16'(m_read(addr)));
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(tag, 16'(rdata), 16'(exp));
  endtask

  task automatic duty(input string tag, input int exp);
    int hi = 0;
    for (int i = 0; i < 256; i++) begin
      tick();
      if (pwm) hi++;
    end
    chk(tag, 16'(hi), 16'(exp));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int unsigned r;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd_reg("R1 cfg reset", 2'd0, 8'h00);
    rd_reg("R1 mode reset", 2'd3, 8'h00);
    rd_reg("R1 cmp reset", 2'd1, 8'h00);
    rd_reg("R1 cmp hi reset", 2'd2, 8'h00);
    // R3 duty in 8-bit mode
    wr_reg(2'd1, 8'h40);
    duty("R3 duty 64/256", 64);
    wr_reg(2'd1, 8'h00);
    duty("R3 zero duty", 0);
    // R2 banking
    wr_reg(2'd1, 8'h12);
    wr_reg(2'd0, cfgb(1, 0, 0, 0, 3'd0));
    wr_reg(2'd1, 8'h34);
    wr_reg(2'd2, 8'h01);
    rd_reg("R2 shadow lo", 2'd1, 8'h34);
    rd_reg("R2 shadow hi", 2'd2, 8'h01);
    wr_reg(2'd0, cfgb(0, 0, 0, 0, 3'd0));
    rd_reg("R2 cmp lo", 2'd1, 8'h12);
    rd_reg("R2 cmp hi", 2'd2, 8'h00);
    // R5 8-bit mode: no reload, no flag
    repeat (300) tick();
    rd_reg("R5 no flag", 2'd0, cfgb(0, 0, 0, 0, 3'd0));
    rd_reg("R5 no reload", 2'd1, 8'h12);
    // R4 9-bit reload
    wr_reg(2'd0, cfgb(1, 0, 0, 0, 3'd1));
    wr_reg(2'd1, 8'h80);
    wr_reg(2'd2, 8'h00);
    while ((m_cnt & 16'h01FF) != 16'h0000) tick();
    rd_reg("R6 flag after wrap", 2'd0, cfgb(1, 1, 0, 0, 3'd1));
    wr_reg(2'd0, cfgb(0, 1, 0, 0, 3'd1));
    rd_reg("R4 reloaded", 2'd1, 8'h80);
    wr_reg(2'd0, cfgb(1, 1, 0, 0, 3'd1));
    wr_reg(2'd1, 8'h20);
    wr_reg(2'd0, cfgb(0, 1, 0, 0, 3'd1));
    rd_reg("R4 mid-period unchanged", 2'd1, 8'h80);
    tick();
    while ((m_cnt & 16'h01FF) != 16'h0000) tick();
    rd_reg("R4 next period", 2'd1, 8'h20);
    // R6 software clear and set
    wr_reg(2'd0, cfgb(0, 0, 0, 0, 3'd1));
    rd_reg("R6 sw clear", 2'd0, cfgb(0, 0, 0, 0, 3'd1));
    wr_reg(2'd0, cfgb(0, 1, 0, 0, 3'd1));
    rd_reg("R6 sw set", 2'd0, cfgb(0, 1, 0, 0, 3'd1));
    // R8 interrupt gating
    chk("R8 masked", 16'(irq), 16'd0);
    wr_reg(2'd0, cfgb(0, 1, 1, 0, 3'd1));
    chk("R8 enabled", 16'(irq), 16'd1);
    wr_reg(2'd0, cfgb(0, 0, 1, 0, 3'd1));
    chk("R8 flag clear", 16'(irq), 16'd0);
    // R7 hardware set wins over same-cycle clear
    while ((m_cnt & 16'h01FF) != 16'h01FF) tick();
    wr_reg(2'd0, cfgb(0, 0, 1, 0, 3'd1));
    rd_reg("R7 hw wins", 2'd0, cfgb(0, 1, 1, 0, 3'd1));
    chk("R7 irq", 16'(irq), 16'd1);
    // random phase, short periods
    for (int i = 0; i < 10000; i++) begin
      r = $urandom;
      addr = r[1:0];
      if (r[4:2] == 3'd0) begin
        wdata = r[15:8];
        if (r[1:0] == 2'd0) wdata[6] = 1'b0;
        if (r[1:0] == 2'd3) wdata = 8'h00;
        wr = 1'b1;
      end
      tick();
      wr = 1'b0;
    end
    // R10 wide mode, reload disabled, length field ignored
    wr_reg(2'd0, cfgb(1, 0, 0, 0, 3'd3));
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h40);
    wr_reg(2'd0, cfgb(0, 0, 0, 0, 3'd3));
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h20);
    wr_reg(2'd3, 8'h01);
    rd_reg("R1 mode bit", 2'd3, 8'h01);
    tick();
    while (m_cnt != 16'h0000) tick();
    rd_reg("R10 cmp kept", 2'd2, 8'h20);
    rd_reg("R9 no flag, len ignored", 2'd0, cfgb(0, 0, 0, 0, 3'd3));
    // R9 wide mode with reload
    wr_reg(2'd0, cfgb(0, 0, 0, 1, 3'd3));
    rd_reg("R9 before wrap", 2'd2, 8'h20);
    while (m_cnt != 16'h0000) tick();
    rd_reg("R9 reloaded", 2'd2, 8'h40);
    rd_reg("R9 no flag", 2'd0, cfgb(0, 0, 0, 1, 3'd3));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule